// File: doc/BRIEF.md
# Length-Prefixed SPI Command Streamer

This block plays a table of display-controller commands out over a write-only four-wire SPI link. The table is a run of records. Each record holds a count byte N, then an opcode byte, then exactly N parameter bytes. The block reads the table one byte at a time through an asynchronous read port, sending each opcode with the data/command line low and each parameter with it high. Chip select frames every record on its own.

A host places the table in a small ROM or register array and gives its base address and byte length. It then pulses `start`. The block walks the records in order, going from each record to the one that begins N + 2 bytes later. It stops when the read pointer reaches base + length and then pulses `done`. Before chip select falls, the block checks that the whole record lies inside the table. If a record would run past the end, nothing of that record goes out, and the run ends with `done` and a held error flag.

Top module: `spi_cmd_streamer`

## Requirements
- R1: For each record the bytes go out in table order: the opcode at record address + 1, then the N parameters at + 2 onward. The next record starts at record address + N + 2.
- R2: A record with count 0 sends its opcode byte alone.
- R3: The opcode byte goes out with `spi_dc` = 0 (command) and every parameter byte with `spi_dc` = 1 (data). Each chip-select frame carries exactly one command byte, and it is the frame's first byte.
- R4: The count field is a full 8-bit value, and records with 70 and 255 parameter bytes are sent completely.
- R5: SPI mode 0, MSB first. `spi_sclk` idles low and has a period of exactly SCLK_DIV system clocks within a byte. `spi_mosi` holds steady while `spi_sclk` is high.
- R6: `spi_dc` has held its value for at least SCLK_DIV/2 system clocks when the first rising `spi_sclk` edge of a byte occurs, and it does not change while `spi_sclk` is high inside a frame.
- R7: `spi_cs_n` is high after reset. It goes low once per record and stays high for at least SCLK_DIV system clocks between records. `spi_sclk` is low whenever `spi_cs_n` is high.
- R8: The run ends when the pointer equals base + length. `done` is high for exactly one cycle per run. With a length of 0, `done` is high in the cycle after the second rising clock edge that follows the edge sampling `start`, counting that edge as the first.
- R9: A `start` pulse while a run is in progress has no effect. The byte stream and the single `done` pulse are those of the first run.
- R10: If a record's end (address + N + 2) exceeds base + length, none of its bytes is sent and no partial byte is sent. The earlier records go out normally. `done` pulses and `err` is set together with it. `err` stays high until the next accepted `start` clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (ignored while running) |
| tbl_base | input | AW | Byte address of the first record |
| tbl_len | input | AW | Table length in bytes |
| rom_addr | output | AW | Table read address |
| rom_data | input | 8 | Table byte at `rom_addr`, same cycle |
| spi_sclk | output | 1 | SPI clock, mode 0 |
| spi_mosi | output | 1 | SPI data out, MSB first |
| spi_cs_n | output | 1 | Chip select, low during a record |
| spi_dc | output | 1 | 0 = command byte, 1 = parameter byte |
| done | output | 1 | One-cycle pulse at the end of a run |
| err | output | 1 | Record overran the table, held until next start |

## Verification
Two results are tied to exact cycles. For an empty table, and for a table whose first record already overruns, the bench samples `done` and `err` in the cycle after the second edge following the accepted `start`. It then expects `done` low in the next cycle. It also expects `err` to read low one cycle after any accepted `start`. Everything on the wire is checked by a monitor that samples mid-cycle on every clock: it rebuilds bytes at rising `spi_sclk` edges, measures the edge spacing, the age of `spi_dc` at each byte's first edge and the chip-select high time, and counts command bytes per frame. At the end of each run the captured (DC, byte) list is compared with one the bench derives by walking the table itself. It also checks that exactly one `done` was seen, waiting 16 extra cycles for any late activity first.

// File: rtl/spi_cs_pkg.sv
`timescale 1ns/1ps
package spi_cs_pkg;

    // Record walker states
    typedef enum logic [2:0] {
        WK_IDLE,
        WK_FETCH,
        WK_LOAD,
        WK_SHIFT,
        WK_GAP
    } walk_st_e;

    // One byte handed to the shifter, with its data/command tag
    typedef struct packed {
        logic       is_data;
        logic [7:0] value;
    } spi_byte_t;

    // Bytes a record occupies: count byte + opcode + parameters
    function automatic logic [8:0] rec_span(input logic [7:0] n);
        return {1'b0, n} + 9'd2;
    endfunction

endpackage

// File: rtl/spi_byte_shifter.sv
`timescale 1ns/1ps
module spi_byte_shifter
    import spi_cs_pkg::*;
#(
    parameter int SCLK_DIV = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  spi_byte_t byte_in,
    output logic      sclk,
    output logic      mosi,
    output logic      dc,
    output logic      tx_done
);
    localparam int HALF = SCLK_DIV / 2;
    localparam int CW   = $clog2(HALF + 1);

    logic          active;
    logic          sclk_r;
    logic [CW-1:0] cnt;
    logic [2:0]    bitn;
    logic [7:0]    shreg;
    logic          dc_r;
    logic          done_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            sclk_r <= 1'b0;
            cnt    <= '0;
            bitn   <= '0;
            shreg  <= '0;
            dc_r   <= 1'b0;
            done_r <= 1'b0;
        end else begin
            done_r <= 1'b0;
            if (load && !active) begin
                active <= 1'b1;
                sclk_r <= 1'b0;
                cnt    <= '0;
                bitn   <= '0;
                shreg  <= byte_in.value;
                dc_r   <= byte_in.is_data;
            end else if (active) begin
                if (cnt == CW'(HALF - 1)) begin
                    cnt <= '0;
                    if (!sclk_r) begin
                        sclk_r <= 1'b1;
                    end else begin
                        sclk_r <= 1'b0;
                        if (bitn == 3'd7) begin
                            active <= 1'b0;
                            done_r <= 1'b1;
                        end else begin
                            bitn  <= bitn + 3'd1;
                            shreg <= {shreg[6:0], 1'b0};
                        end
                    end
                end else begin
                    cnt <= cnt + CW'(1);
                end
            end
        end
    end

    assign sclk    = sclk_r;
    assign mosi    = shreg[7];
    assign dc      = dc_r;
    assign tx_done = done_r;

    AST_MOSI_HOLD: assert property (@(posedge clk) disable iff (rst)
        (sclk_r && $past(sclk_r)) |-> $stable(mosi)); // R5
    AST_LOAD_IDLE: assert property (@(posedge clk) disable iff (rst)
        load |-> !active); // R1

endmodule

// File: rtl/cs_record_walker.sv
`timescale 1ns/1ps
module cs_record_walker
    import spi_cs_pkg::*;
#(
    parameter int AW       = 10,
    parameter int SCLK_DIV = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW-1:0] tbl_base,
    input  logic [AW-1:0] tbl_len,
    output logic [AW-1:0] rom_addr,
    input  logic [7:0]    rom_data,
    output logic          tx_load,
    output spi_byte_t     tx_byte,
    input  logic          tx_done,
    output logic          cs_n,
    output logic          done,
    output logic          err
);
    localparam int EW = AW + 1;
    localparam int GW = $clog2(SCLK_DIV + 1);

    walk_st_e      st;
    logic [EW-1:0] ptr;
    logic [EW-1:0] end_a;
    logic [EW-1:0] rd;
    logic [EW-1:0] nxt;
    logic [8:0]    left;
    logic          first;
    logic [GW-1:0] gap;
    logic          cs_n_r;
    logic          done_r;
    logic          err_r;
    logic [EW:0]   rec_lim;

    assign rec_lim = {1'b0, ptr} + (EW + 1)'(rec_span(rom_data));

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= WK_IDLE;
            ptr    <= '0;
            end_a  <= '0;
            rd     <= '0;
            nxt    <= '0;
            left   <= '0;
            first  <= 1'b0;
            gap    <= '0;
            cs_n_r <= 1'b1;
            done_r <= 1'b0;
            err_r  <= 1'b0;
        end else begin
            done_r <= 1'b0;
            case (st)
                WK_IDLE: begin
                    if (start) begin
                        ptr   <= {1'b0, tbl_base};
                        end_a <= {1'b0, tbl_base} + {1'b0, tbl_len};
                        err_r <= 1'b0;
                        st    <= WK_FETCH;
                    end
                end
                WK_FETCH: begin
                    if (ptr == end_a) begin
                        done_r <= 1'b1;
                        st     <= WK_IDLE;
                    end else if (rec_lim > {1'b0, end_a}) begin
                        done_r <= 1'b1;
                        err_r  <= 1'b1;
                        st     <= WK_IDLE;
                    end else begin
                        nxt    <= rec_lim[EW-1:0];
                        rd     <= ptr + EW'(1);
                        left   <= {1'b0, rom_data} + 9'd1;
                        first  <= 1'b1;
                        cs_n_r <= 1'b0;
                        st     <= WK_LOAD;
                    end
                end
                WK_LOAD: st <= WK_SHIFT;
                WK_SHIFT: begin
                    if (tx_done) begin
                        rd    <= rd + EW'(1);
                        first <= 1'b0;
                        left  <= left - 9'd1;
                        if (left == 9'd1) begin
                            cs_n_r <= 1'b1;
                            gap    <= '0;
                            st     <= WK_GAP;
                        end else begin
                            st <= WK_LOAD;
                        end
                    end
                end
                WK_GAP: begin
                    if (gap == GW'(SCLK_DIV - 1)) begin
                        ptr <= nxt;
                        st  <= WK_FETCH;
                    end else begin
                        gap <= gap + GW'(1);
                    end
                end
                default: st <= WK_IDLE;
            endcase
        end
    end

    assign rom_addr        = (st == WK_FETCH) ? ptr[AW-1:0] : rd[AW-1:0];
    assign tx_load         = (st == WK_LOAD);
    assign tx_byte.is_data = !first;
    assign tx_byte.value   = rom_data;
    assign cs_n            = cs_n_r;
    assign done            = done_r;
    assign err             = err_r;

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done_r |=> !done_r); // R8
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (st != WK_IDLE && start) |=> $stable(end_a)); // R9
    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        $rose(err_r) |-> done_r); // R10
    AST_ERR_NO_FRAME: assert property (@(posedge clk) disable iff (rst)
        err_r |-> cs_n_r); // R10

endmodule

// File: rtl/spi_cmd_streamer.sv
`timescale 1ns/1ps
module spi_cmd_streamer
    import spi_cs_pkg::*;
#(
    parameter int AW       = 10,
    parameter int SCLK_DIV = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW-1:0] tbl_base,
    input  logic [AW-1:0] tbl_len,
    output logic [AW-1:0] rom_addr,
    input  logic [7:0]    rom_data,
    output logic          spi_sclk,
    output logic          spi_mosi,
    output logic          spi_cs_n,
    output logic          spi_dc,
    output logic          done,
    output logic          err
);
    logic      tx_load;
    logic      tx_done;
    spi_byte_t tx_byte;

    cs_record_walker #(.AW(AW), .SCLK_DIV(SCLK_DIV)) u_walk (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .tbl_base (tbl_base),
        .tbl_len  (tbl_len),
        .rom_addr (rom_addr),
        .rom_data (rom_data),
        .tx_load  (tx_load),
        .tx_byte  (tx_byte),
        .tx_done  (tx_done),
        .cs_n     (spi_cs_n),
        .done     (done),
        .err      (err)
    );

    spi_byte_shifter #(.SCLK_DIV(SCLK_DIV)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .load    (tx_load),
        .byte_in (tx_byte),
        .sclk    (spi_sclk),
        .mosi    (spi_mosi),
        .dc      (spi_dc),
        .tx_done (tx_done)
    );

    AST_SCLK_QUIET: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n |-> !spi_sclk); // R7
    AST_DC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!spi_cs_n && spi_sclk) |-> $stable(spi_dc)); // R6

endmodule

// File: tb/spi_cmd_streamer_test.sv
`timescale 1ns/1ps
module spi_cmd_streamer_test;
    localparam int AW       = 10;
    localparam int SCLK_DIV = 4;
    localparam int HALF     = SCLK_DIV / 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [AW-1:0] tbl_base = '0;
    logic [AW-1:0] tbl_len = '0;
    logic [AW-1:0] rom_addr;
    logic [7:0]    rom_data;
    logic          spi_sclk, spi_mosi, spi_cs_n, spi_dc, done, err;
    logic [7:0]    mem [0:(1<<AW)-1];

    assign rom_data = mem[rom_addr];

    spi_cmd_streamer #(.AW(AW), .SCLK_DIV(SCLK_DIV)) uut (
        .clk(clk), .rst(rst), .start(start), .tbl_base(tbl_base),
        .tbl_len(tbl_len), .rom_addr(rom_addr), .rom_data(rom_data),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n),
        .spi_dc(spi_dc), .done(done), .err(err)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected<190000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // Wire monitor: samples mid-cycle on every clock
    logic       p_sclk = 1'b0, p_cs_n = 1'b1, p_dc = 1'b0;
    int         dc_age = 0, hi_run = 0, rise_gap = 0, bitn = 0;
    int         fr_cmds = 0, frames = 0, done_seen = 0;
    logic [7:0] sh = '0;
    logic [8:0] capq [$];

    always @(negedge clk) begin
        if (!rst) begin
            if (spi_dc !== p_dc) dc_age = 0; else dc_age++;
            rise_gap++;
            if (spi_cs_n) chk(!spi_sclk, "R7", "sclk high outside frame", spi_sclk, 0);
            if (!spi_cs_n && p_cs_n) begin
                chk(hi_run >= SCLK_DIV, "R7", "cs_n high time", hi_run, SCLK_DIV);
                fr_cmds = 0;
                bitn = 0;
            end
            if (spi_sclk && !p_sclk && !spi_cs_n) begin
                if (bitn == 0)
                    chk(dc_age >= HALF, "R6", "dc setup cycles", dc_age, HALF);
                else
                    chk(rise_gap == SCLK_DIV, "R5", "sclk period", rise_gap, SCLK_DIV);
                rise_gap = 0;
                sh = {sh[6:0], spi_mosi};
                bitn++;
                if (bitn == 8) begin
                    capq.push_back({spi_dc, sh});
                    if (!spi_dc) fr_cmds++;
                    bitn = 0;
                end
            end
            if (spi_cs_n && !p_cs_n) begin
                chk(fr_cmds == 1, "R3", "command bytes in frame", fr_cmds, 1);
                chk(bitn == 0, "R10", "partial byte bits", bitn, 0);
                frames++;
            end
            if (spi_cs_n) hi_run++; else hi_run = 0;
            if (done) done_seen++;
            p_sclk = spi_sclk;
            p_cs_n = spi_cs_n;
            p_dc   = spi_dc;
        end
    end

    task automatic run_table(input int base, input int len, input int inject_at,
                             input int ibase, input string tag);
        logic [8:0] expq [$];
        int  exp_frames = 0;
        bit  exp_err = 1'b0;
        int  p = base;
        int  w = 0;
        while (p < base + len) begin
            int n = mem[p];
            if (p + n + 2 > base + len) begin
                exp_err = 1'b1;
                break;
            end
            expq.push_back({1'b0, mem[p+1]});
            for (int i = 0; i < n; i++) expq.push_back({1'b1, mem[p+2+i]});
            exp_frames++;
            p = p + n + 2;
        end
        capq.delete();
        frames = 0;
        done_seen = 0;
        @(negedge clk);
        start = 1'b1;
        tbl_base = AW'(base);
        tbl_len = AW'(len);
        @(negedge clk);
        start = 1'b0;
        while (!done && w < 150000) begin
            @(negedge clk);
            w++;
            if (w == inject_at) begin
                start = 1'b1;
                tbl_base = AW'(ibase);
            end else begin
                start = 1'b0;
                tbl_base = AW'(base);
            end
        end
        start = 1'b0;
        repeat (SCLK_DIV * 4) @(negedge clk);
        chk(done_seen == 1, "R8", {tag, " done pulses"}, done_seen, 1);
        chk(err == exp_err, "R10", {tag, " err flag"}, err, exp_err);
        chk(frames == exp_frames, "R7", {tag, " frames"}, frames, exp_frames);
        chk(capq.size() == expq.size(), tag, "byte count", capq.size(), expq.size());
        for (int i = 0; i < expq.size() && i < capq.size(); i++)
            chk(capq[i] == expq[i], tag, "dc/byte", capq[i], expq[i]);
    endtask

    task automatic quick_end(input int base, input int len, input bit exp_err,
                             input string tag);
        capq.delete();
        @(negedge clk);
        start = 1'b1;
        tbl_base = AW'(base);
        tbl_len = AW'(len);
        @(negedge clk);
        start = 1'b0;
        chk(err == 1'b0, "R10", {tag, " err cleared by start"}, err, 0);
        chk(done == 1'b0, "R8", {tag, " done early"}, done, 0);
        @(negedge clk);
        chk(done == 1'b1, "R8", {tag, " done at second edge"}, done, 1);
        chk(err == exp_err, "R10", {tag, " err at second edge"}, err, exp_err);
        @(negedge clk);
        chk(done == 1'b0, "R8", {tag, " done width"}, done, 0);
        chk(err == exp_err, "R10", {tag, " err held"}, err, exp_err);
        repeat (SCLK_DIV * 2) @(negedge clk);
        chk(capq.size() == 0, "R10", {tag, " bytes sent"}, capq.size(), 0);
        chk(spi_cs_n == 1'b1, "R7", {tag, " cs_n idle"}, spi_cs_n, 1);
    endtask

    initial begin
        for (int i = 0; i < (1 << AW); i++) mem[i] = 8'h00;
        // base 16: four short records, including a count of 0
        mem[16] = 8'd0; mem[17] = 8'h12;
        mem[18] = 8'd1; mem[19] = 8'h2C; mem[20] = 8'h26;
        mem[21] = 8'd3; mem[22] = 8'h01; mem[23] = 8'hF9; mem[24] = 8'h00; mem[25] = 8'h00;
        mem[26] = 8'd2; mem[27] = 8'h44; mem[28] = 8'h00; mem[29] = 8'h0F;
        // base 100: 70 parameters
        mem[100] = 8'd70; mem[101] = 8'h32;
        for (int i = 0; i < 70; i++) mem[102+i] = 8'((i * 7 + 3) & 8'hFF);
        // base 300: 255 parameters
        mem[300] = 8'd255; mem[301] = 8'h5A;
        for (int i = 0; i < 255; i++) mem[302+i] = 8'(i) ^ 8'hA5;
        // base 600: one good record, then one that overruns
        mem[600] = 8'd1; mem[601] = 8'h3C; mem[602] = 8'h03;
        mem[603] = 8'd5; mem[604] = 8'h22; mem[605] = 8'hC0; mem[606] = 8'hAA;
        // base 700: count byte only
        mem[700] = 8'd0;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(spi_cs_n == 1'b1, "R7", "reset cs_n", spi_cs_n, 1);
        chk(spi_sclk == 1'b0, "R5", "reset sclk", spi_sclk, 0);
        chk(done == 1'b0, "R8", "reset done", done, 0);
        chk(err == 1'b0, "R10", "reset err", err, 0);

        quick_end(0, 0, 1'b0, "R8 empty");
        run_table(16, 14, -1, 0, "R1 R2 R3 short");
        run_table(100, 72, -1, 0, "R4 len70");
        run_table(300, 257, -1, 0, "R4 len255");
        run_table(16, 14, 30, 100, "R9 restart");
        run_table(600, 7, -1, 0, "R10 overrun");
        quick_end(700, 1, 1'b1, "R10 first");
        quick_end(0, 0, 1'b0, "R10 clear");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule